// File: doc/BRIEF.md
# Bit-Serial Codec Command Shifter

This block connects a byte-wide host register port to the serial control port of two external audio converters. The host never hands it a whole command word. It opens a frame by reading a chosen address, sends the command one bit per host write, and closes the frame by reading a third address. Bit 7 of every written byte carries the serial bit, and the other seven bits of the byte are ignored.

Two targets share the serial clock and data lines, and each target has its own active-low select. The output converter accepts 16-bit commands. Typical commands are a left level of 0xA600 plus a level code, a right level of 0xA700 plus a level code, mute 0xA38D, unmute 0xA30D, and a speed mode of 0xA240 below 55 kHz or 0xA24D above it. The input converter accepts 32-bit level frames, which carry the mic level twice, then the right line level, then the left line level, each 8 bits wide.

Each accepted write first places its bit on the data line. One system cycle later the serial clock goes high, and it stays high for a fixed number of cycles. A counter shows how many bits the current frame holds.

Top module: `codec_cmd_shifter`

## Requirements
- R1: After reset both selects are high, the serial clock and data are low, and the bit count is 0.
- R2: A read of address OPEN_OUT_ADDR (default 0x0C) pulls out_sel_n low on the next cycle, keeps in_sel_n high and clears the bit count.
- R3: A read of address DATA_ADDR (default 0x04) pulls in_sel_n low on the next cycle, keeps out_sel_n high and clears the bit count.
- R4: A read of address CLOSE_ADDR (default 0x08) drives both selects high and the serial clock low on the next cycle, and leaves the bit count unchanged.
- R5: A write to DATA_ADDR that is accepted puts bit 7 of the written byte on ser_data on the next cycle. One cycle after that, ser_clk rises and bit_count goes up by one. ser_clk then stays high for CLK_HI cycles (default 2).
- R6: A data write while no frame is open is ignored: ser_clk does not pulse, and bit_count and ser_data keep their values.
- R7: A data write that arrives while a clock pulse is still in progress (from the write cycle until ser_clk has fallen) is ignored.
- R8: Once a frame holds its full length (16 bits for the output target, 32 bits for the input target), further data writes are ignored.
- R9: Bits leave in the order they were written, so an MSB-first host sequence reaches the converter as the full command word. Examples are 0xA38D, 0xA30D, 0xA240, 0xA24D, 0xA600 + level, 0xA700 + level, and the input frame {mic, mic, right, left}.
- R10: At most one select is low at any time. An open read issued while a frame is open switches to the new target and clears the count.
- R11: ser_data stays stable while ser_clk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Host register address |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_wdata | input | 8 | Host write byte; only bit 7 is used |
| out_sel_n | output | 1 | Active-low select of the output converter |
| in_sel_n | output | 1 | Active-low select of the input converter |
| ser_clk | output | 1 | Serial clock, one pulse per accepted bit |
| ser_data | output | 1 | Serial data, valid from one cycle before the ser_clk rise |
| bit_count | output | $clog2(IN_BITS+1) | Number of bits shifted in the current or last frame |

## Verification
Wrong internal state becomes visible at the ports within a few cycles. A wrong frame-target flag shows up one cycle after the open or close read, either as both selects low or as the wrong select. A wrong pulse phase or high-time counter changes the ser_clk width or lets a second write through, and this shows up within CLK_HI+2 cycles as an extra or missing pulse. A wrong count limit shows up as a 17th or 33rd pulse, or as a converter word that differs from the command that was sent. The bench samples the serial lines the way a converter would, rebuilds each word, and compares it with the command the host meant to send.

// File: rtl/codec_cmd_shifter.sv
module codec_cmd_shifter #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR     = 8'h04,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR    = 8'h08,
  parameter logic [ADDR_W-1:0] OPEN_OUT_ADDR = 8'h0C,
  parameter int OUT_BITS = 16,
  parameter int IN_BITS  = 32,
  parameter int CLK_HI   = 2,
  localparam int CNT_W = $clog2(IN_BITS + 1),
  localparam int HI_W  = $clog2(CLK_HI + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic              out_sel_n,
  output logic              in_sel_n,
  output logic              ser_clk,
  output logic              ser_data,
  output logic [CNT_W-1:0]  bit_count
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH} phase_t;

  localparam logic [CNT_W-1:0] OUT_LIM = CNT_W'(OUT_BITS);
  localparam logic [CNT_W-1:0] IN_LIM  = CNT_W'(IN_BITS);
  localparam logic [HI_W-1:0]  HI_LIM  = HI_W'(CLK_HI);

  phase_t          phase;
  logic            open_out, open_in;
  logic [HI_W-1:0] hi_cnt;

  wire rd_close    = bus_rd && bus_addr == CLOSE_ADDR;
  wire rd_open_out = bus_rd && bus_addr == OPEN_OUT_ADDR;
  wire rd_open_in  = bus_rd && bus_addr == DATA_ADDR;
  wire [CNT_W-1:0] limit = open_out ? OUT_LIM : IN_LIM;
  wire take_bit = bus_wr && !bus_rd && bus_addr == DATA_ADDR &&
                  (open_out || open_in) && phase == PH_IDLE && bit_count < limit;

  assign out_sel_n = !open_out;
  assign in_sel_n  = !open_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_out  <= 1'b0;
      open_in   <= 1'b0;
      phase     <= PH_IDLE;
      hi_cnt    <= '0;
      ser_clk   <= 1'b0;
      ser_data  <= 1'b0;
      bit_count <= '0;
    end else if (rd_close) begin
      open_out <= 1'b0;
      open_in  <= 1'b0;
      phase    <= PH_IDLE;
      ser_clk  <= 1'b0;
    end else if (rd_open_out || rd_open_in) begin
      open_out  <= rd_open_out;
      open_in   <= rd_open_in;
      phase     <= PH_IDLE;
      ser_clk   <= 1'b0;
      bit_count <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (take_bit) begin
          ser_data <= bus_wdata[7];
          phase    <= PH_SETUP;
        end
        PH_SETUP: begin
          ser_clk   <= 1'b1;
          bit_count <= bit_count + 1'b1;
          hi_cnt    <= HI_W'(1);
          phase     <= PH_HIGH;
        end
        PH_HIGH: begin
          if (hi_cnt == HI_LIM) begin
            ser_clk <= 1'b0;
            phase   <= PH_IDLE;
          end else begin
            hi_cnt <= hi_cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/codec_cmd_shifter_chk.sv
module codec_cmd_shifter_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR     = 8'h04,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR    = 8'h08,
  parameter logic [ADDR_W-1:0] OPEN_OUT_ADDR = 8'h0C,
  parameter int OUT_BITS = 16,
  parameter int IN_BITS  = 32,
  localparam int CNT_W = $clog2(IN_BITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              out_sel_n,
  input logic              in_sel_n,
  input logic              ser_clk,
  input logic              ser_data,
  input logic [CNT_W-1:0]  bit_count
);

  // R10
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel_n || in_sel_n);

  // R2
  open_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OPEN_OUT_ADDR) |=> (!out_sel_n && in_sel_n && bit_count == '0));

  // R3
  open_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DATA_ADDR) |=> (!in_sel_n && out_sel_n && bit_count == '0));

  // R4
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CLOSE_ADDR) |=> (out_sel_n && in_sel_n && !ser_clk && $stable(bit_count)));

  // R5
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> bit_count == CNT_W'($past(bit_count) + 1'b1));

  // R6
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && out_sel_n && in_sel_n) |=> ($stable(bit_count) && !ser_clk));

  // R8
  out_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_sel_n |-> bit_count <= CNT_W'(OUT_BITS));

  // R8
  in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CNT_W'(IN_BITS));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

endmodule

bind codec_cmd_shifter codec_cmd_shifter_chk #(
  .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CLOSE_ADDR(CLOSE_ADDR),
  .OPEN_OUT_ADDR(OPEN_OUT_ADDR), .OUT_BITS(OUT_BITS), .IN_BITS(IN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .out_sel_n(out_sel_n), .in_sel_n(in_sel_n), .ser_clk(ser_clk),
  .ser_data(ser_data), .bit_count(bit_count)
);

// File: tb/codec_cmd_shifter_bench.sv
module codec_cmd_shifter_bench;
  localparam logic [7:0] A_DATA = 8'h04, A_CLOSE = 8'h08, A_OPEN = 8'h0C;
  localparam int CLK_HI = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic out_sel_n, in_sel_n, ser_clk, ser_data;
  logic [5:0] bit_count;

  int total = 0, bad = 0;
  int rises = 0;
  logic [31:0] rx = '0;
  bit done = 0;

  always #2 clk = ~clk;

  codec_cmd_shifter u_codec_cmd_shifter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .out_sel_n(out_sel_n), .in_sel_n(in_sel_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .bit_count(bit_count)
  );

  always @(posedge ser_clk) begin
    rises++;
    rx = {rx[30:0], ser_data};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      do_write(A_DATA, w[i] ? 8'h80 : 8'h7F);
      repeat (CLK_HI + 2) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 out_sel_n", out_sel_n, 1);
    chk("R1 in_sel_n", in_sel_n, 1);
    chk("R1 ser_clk", ser_clk, 0);
    chk("R1 ser_data", ser_data, 0);
    chk("R1 bit_count", bit_count, 0);
  endtask

  task automatic t_out_cmd(input logic [15:0] cmd);
    do_read(A_OPEN);
    chk("R2 out_sel_n", out_sel_n, 0);
    chk("R2 in_sel_n", in_sel_n, 1);
    chk("R2 count", bit_count, 0);
    send_bits({16'h0, cmd}, 16);
    chk("R9 count", bit_count, 16);
    do_read(A_CLOSE);
    chk("R4 sel", {out_sel_n, in_sel_n}, 2'b11);
    chk("R4 count held", bit_count, 16);
    chk("R9 word", rx[15:0], cmd);
  endtask

  task automatic t_in_frame(input logic [7:0] mic, input logic [7:0] r, input logic [7:0] l);
    do_read(A_DATA);
    chk("R3 in_sel_n", in_sel_n, 0);
    chk("R3 out_sel_n", out_sel_n, 1);
    send_bits({mic, mic, r, l}, 32);
    chk("R9 in count", bit_count, 32);
    chk("R9 in frame", rx, {mic, mic, r, l});
    do_read(A_CLOSE);
  endtask

  task automatic t_timing;
    do_read(A_OPEN);
    do_write(A_DATA, 8'h80);
    chk("R5 data setup", ser_data, 1);
    chk("R5 clk low at setup", ser_clk, 0);
    @(negedge clk);
    chk("R5 clk rise", ser_clk, 1);
    chk("R5 count", bit_count, 1);
    @(negedge clk);
    chk("R5 clk still high", ser_clk, 1);
    @(negedge clk);
    chk("R5 clk fall", ser_clk, 0);
    do_read(A_CLOSE);
  endtask

  task automatic t_idle_write;
    int r0 = rises;
    logic [5:0] c0 = bit_count;
    logic d0 = ser_data;
    do_write(A_DATA, d0 ? 8'h00 : 8'h80);
    repeat (CLK_HI + 3) @(negedge clk);
    chk("R6 no pulse", rises, r0);
    chk("R6 count", bit_count, c0);
    chk("R6 data", ser_data, d0);
  endtask

  task automatic t_busy_write;
    int r0;
    do_read(A_OPEN);
    r0 = rises;
    do_write(A_DATA, 8'h80);
    do_write(A_DATA, 8'h00);
    repeat (CLK_HI + 3) @(negedge clk);
    chk("R7 one pulse", rises, r0 + 1);
    chk("R7 count", bit_count, 1);
    chk("R7 data kept", ser_data, 1);
    do_read(A_CLOSE);
  endtask

  task automatic t_overflow;
    int r0;
    do_read(A_OPEN);
    r0 = rises;
    send_bits(32'h0003_5A5A, 18);
    chk("R8 count cap", bit_count, 16);
    chk("R8 pulses", rises, r0 + 16);
    chk("R8 word", rx[15:0], 16'hD696);
    do_read(A_CLOSE);
  endtask

  task automatic t_switch;
    do_read(A_OPEN);
    send_bits(32'h5, 3);
    chk("R10 partial", bit_count, 3);
    do_read(A_DATA);
    chk("R10 sel", {out_sel_n, in_sel_n}, 2'b10);
    chk("R10 count", bit_count, 0);
    do_read(A_CLOSE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_out_cmd(16'hA38D);
    t_out_cmd(16'hA30D);
    t_out_cmd(16'hA240);
    t_out_cmd(16'hA24D);
    t_out_cmd(16'hA600 + 16'h7F);
    t_out_cmd(16'hA700 + 16'hFF);
    t_in_frame(8'hC3, 8'h5A, 8'h81);
    t_idle_write();
    t_busy_write();
    t_overflow();
    t_switch();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule